// File: doc/BRIEF.md
# Set-Reset PWM Compare Channel

This block produces one pulse-width-modulated output from a free-running 16-bit timebase and one compare channel. Each time the timebase advances onto the stored compare value, the output is set. Each time the timebase wraps from its all-ones value to zero, the output is cleared. The output therefore stays low for `compare` timebase steps of every 65536 and high for the rest, so the duty cycle is (65536 - compare) / 65536. A compare value of zero keeps the output high. The all-ones value keeps it high for a single step. A disarmed channel holds the output low, which gives 0% duty.

Software reaches the channel over a byte-write bus. It loads the compare value low byte first. That write disarms the channel, so a half-written value can never produce a match. The following high-byte write re-arms the channel. Two sticky flags report events: a match flag, which is gated by a flag enable, and an overflow flag. A match interrupt request is raised from the match flag when both enables are set. The timebase only advances on cycles where its clock-enable input is high. Both bytes of the counter can be loaded from the bus.

Top module: `sr_pwm_channel`

## Requirements
- R1: After reset the counter, the compare value, the armed bit, both flags, the interrupt request and the PWM output are all 0.
- R2: The counter advances by one, wrapping 0xFFFF to 0x0000, on each cycle where `tb_ce` is high. It holds while `tb_ce` is low. A write to address 4 (count bits 7:0) or address 5 (count bits 15:8) loads that byte, and the counter does not advance in that cycle.
- R3: When the channel is armed and the counter advances onto the compare value, `pwm_out` is 1 from the same cycle in which `count_out` shows that value.
- R4: When the counter advances from 0xFFFF to 0x0000 onto a value other than the compare value, `pwm_out` becomes 0. With compare = 0 the output stays high through the whole period. With compare = 0xFFFF it is high only while the count is 0xFFFF.
- R5: A write to address 1 (compare bits 7:0) clears the armed bit. A write to address 2 (compare bits 15:8) sets it. A write to control address 0 copies data bit 2 into the armed bit. While the channel is disarmed, `pwm_out` goes to 0 one cycle later and stays 0.
- R6: A match sets `match_flag` only when control bit 0 (flag enable) is 1. A match while bit 0 is 0 leaves the flag unchanged.
- R7: Every counter wrap from 0xFFFF to 0x0000 sets `ovf_flag`, whether or not the channel is armed.
- R8: Both flags are sticky. A write to address 3 clears `match_flag` when data bit 0 is 0 and clears `ovf_flag` when data bit 1 is 0. A 1 in a data bit leaves that flag alone. A hardware set in the same cycle wins over the clear.
- R9: `match_irq` is 1 exactly when `match_flag`, control bit 0 and control bit 1 (interrupt enable) are all 1.
- R10: While `tb_ce` is low, a count that equals the compare value does not produce a new match, so a cleared match flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_ce | input | 1 | Timebase clock enable |
| wr_en | input | 1 | Bus byte-write strobe |
| wr_addr | input | 3 | Bus register address |
| wr_data | input | 8 | Bus write data |
| pwm_out | output | 1 | PWM output |
| count_out | output | 16 | Current timebase count |
| armed_out | output | 1 | Channel armed (comparator enabled) |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky timebase overflow flag |
| match_irq | output | 1 | Match interrupt request |

## Verification
The hardest situation to reach from the ports is a hardware flag set and a software clear landing on the same clock edge. The bench stalls the timebase one step below the compare value. On a single falling edge it then raises `tb_ce` and issues the flag-clear write together, so the match and the clear meet at the next rising edge. The other hard cases sit at the ends of the 65536-step period: the wrap, and the compare values 0 and 0xFFFF. The bench reaches them by loading the counter just below 0xFFFF through the bus. It runs one full period only to confirm that compare = 0 never lets the output drop.

// File: rtl/sr_pwm_pkg.sv
package sr_pwm_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NLANE  = CNT_W / BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_CMP_LO = 3'd1,
    RA_CMP_HI = 3'd2,
    RA_FLAGS  = 3'd3,
    RA_CNT_LO = 3'd4,
    RA_CNT_HI = 3'd5
  } reg_addr_e;

  // control register bit positions
  localparam int CTRL_MATEN = 0;
  localparam int CTRL_IRQEN = 1;
  localparam int CTRL_ARM   = 2;

  // flag register bit positions (write 0 to clear)
  localparam int FLG_MATCH = 0;
  localparam int FLG_OVF   = 1;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base, input int lane);
    return base + lane[ADDR_W-1:0];
  endfunction

  // sticky flag: set has priority over clear
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/sr_pwm_timebase.sv
module sr_pwm_timebase
  import sr_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  count_nxt,
  output logic              step_en
);

  logic             load_any;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_any = 1'b0;
    load_val = count_q;
    for (int i = 0; i < NLANE; i++) begin
      if (wr_en && (wr_addr == lane_addr(RA_CNT_LO, i))) begin
        load_any = 1'b1;
        load_val[i*BYTE_W +: BYTE_W] = wr_data;
      end
    end
  end

  assign step_en   = tb_ce && !load_any;
  assign count_nxt = cnt_inc(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (load_any) count_q <= load_val;
    else if (step_en)  count_q <= count_nxt;
  end

endmodule

// File: rtl/sr_pwm_regs.sv
module sr_pwm_regs
  import sr_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              match_ev,
  input  logic              ovf_ev,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              armed_q,
  output logic              mat_en_q,
  output logic              irq_en_q,
  output logic              match_flag_q,
  output logic              ovf_flag_q,
  output logic              clr_match,
  output logic              clr_ovf
);

  logic wr_ctrl, wr_lo, wr_hi, wr_flags;
  logic [CNT_W-1:0] cmp_d;

  assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign wr_lo    = wr_en && (wr_addr == RA_CMP_LO);
  assign wr_hi    = wr_en && (wr_addr == lane_addr(RA_CMP_LO, NLANE-1));
  assign wr_flags = wr_en && (wr_addr == RA_FLAGS);

  assign clr_match = wr_flags && !wr_data[FLG_MATCH];
  assign clr_ovf   = wr_flags && !wr_data[FLG_OVF];

  always_comb begin
    cmp_d = cmp_q;
    for (int i = 0; i < NLANE; i++) begin
      if (wr_en && (wr_addr == lane_addr(RA_CMP_LO, i)))
        cmp_d[i*BYTE_W +: BYTE_W] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q        <= '0;
      armed_q      <= 1'b0;
      mat_en_q     <= 1'b0;
      irq_en_q     <= 1'b0;
      match_flag_q <= 1'b0;
      ovf_flag_q   <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      if (wr_ctrl) begin
        mat_en_q <= wr_data[CTRL_MATEN];
        irq_en_q <= wr_data[CTRL_IRQEN];
        armed_q  <= wr_data[CTRL_ARM];
      end else if (wr_lo) begin
        armed_q <= 1'b0;
      end else if (wr_hi) begin
        armed_q <= 1'b1;
      end
      match_flag_q <= flag_next(match_flag_q, match_ev && mat_en_q, clr_match);
      ovf_flag_q   <= flag_next(ovf_flag_q, ovf_ev, clr_ovf);
    end
  end

endmodule

// File: rtl/sr_pwm_outstage.sv
module sr_pwm_outstage
  import sr_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             armed_q,
  output logic             match_ev,
  output logic             ovf_ev,
  output logic             pwm_q
);

  // events are judged on the value the counter is stepping onto
  assign match_ev = step_en && armed_q && (count_nxt == cmp_q);
  assign ovf_ev   = step_en && (count_q == CNT_MAX);

  // set-reset latch: disarm forces low, match wins over overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pwm_q <= 1'b0;
    else if (!armed_q) pwm_q <= 1'b0;
    else if (match_ev) pwm_q <= 1'b1;
    else if (ovf_ev)   pwm_q <= 1'b0;
  end

endmodule

// File: rtl/sr_pwm_channel.sv
module sr_pwm_channel
  import sr_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out,
  output logic [CNT_W-1:0]  count_out,
  output logic              armed_out,
  output logic              match_flag,
  output logic              ovf_flag,
  output logic              match_irq
);

  logic [CNT_W-1:0] count_q, count_nxt, cmp_q;
  logic step_en, match_ev, ovf_ev;
  logic armed_q, mat_en_q, irq_en_q;
  logic clr_match, clr_ovf;

  sr_pwm_timebase u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_ce     (tb_ce),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_q   (count_q),
    .count_nxt (count_nxt),
    .step_en   (step_en)
  );

  sr_pwm_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .match_ev     (match_ev),
    .ovf_ev       (ovf_ev),
    .cmp_q        (cmp_q),
    .armed_q      (armed_q),
    .mat_en_q     (mat_en_q),
    .irq_en_q     (irq_en_q),
    .match_flag_q (match_flag),
    .ovf_flag_q   (ovf_flag),
    .clr_match    (clr_match),
    .clr_ovf      (clr_ovf)
  );

  sr_pwm_outstage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .count_q   (count_q),
    .count_nxt (count_nxt),
    .cmp_q     (cmp_q),
    .armed_q   (armed_q),
    .match_ev  (match_ev),
    .ovf_ev    (ovf_ev),
    .pwm_q     (pwm_out)
  );

  assign count_out = count_q;
  assign armed_out = armed_q;
  assign match_irq = match_flag && mat_en_q && irq_en_q;

endmodule

// File: rtl/sr_pwm_checker.sv
module sr_pwm_checker
  import sr_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic [CNT_W-1:0] count_q,
  input logic             pwm_out,
  input logic             armed_q,
  input logic             mat_en_q,
  input logic             match_ev,
  input logic             ovf_ev,
  input logic             match_flag,
  input logic             ovf_flag,
  input logic             match_irq,
  input logic             clr_ovf
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> count_q == cnt_inc($past(count_q)));

  a_r3_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(match_ev));

  a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> ($past(ovf_ev) || !$past(armed_q)));

  a_r5_disarmed_low: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !pwm_out);

  a_r6_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mat_en_q) |=> match_flag);

  a_r7_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_flag);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> (match_flag && mat_en_q));

endmodule

bind sr_pwm_channel sr_pwm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .count_q    (count_q),
  .pwm_out    (pwm_out),
  .armed_q    (armed_q),
  .mat_en_q   (mat_en_q),
  .match_ev   (match_ev),
  .ovf_ev     (ovf_ev),
  .match_flag (match_flag),
  .ovf_flag   (ovf_flag),
  .match_irq  (match_irq),
  .clr_ovf    (clr_ovf)
);

// File: tb/sr_pwm_channel_tb_top.sv
`timescale 1ns/1ps
module sr_pwm_channel_tb_top;

  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2,
                         A_FLG = 3'd3, A_NLO = 3'd4, A_NHI = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pwm_out, armed_out, match_flag, ovf_flag, match_irq;
  logic [15:0] count_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sr_pwm_channel dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_ce      (tb_ce),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pwm_out    (pwm_out),
    .count_out  (count_out),
    .armed_out  (armed_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag),
    .match_irq  (match_irq)
  );

  // bench-side restatement: count of high steps per period for a compare value
  function automatic int high_steps(input int cmpv);
    return 65536 - cmpv;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_count(input logic [15:0] v);
    bus_wr(A_NLO, v[7:0]);
    bus_wr(A_NHI, v[15:8]);
  endtask

  task automatic t_reset();
    check("R1 count", count_out, 0);
    check("R1 pwm", pwm_out, 0);
    check("R1 armed", armed_out, 0);
    check("R1 flags", {match_flag, ovf_flag, match_irq}, 0);
  endtask

  task automatic t_counter();
    load_count(16'h1234);
    step(3);
    check("R2 load/hold", count_out, 16'h1234);
    tb_ce = 1'b1; step(5); tb_ce = 1'b0;
    check("R2 advance", count_out, 16'h1239);
    load_count(16'hFFFE);
    tb_ce = 1'b1; step(2); tb_ce = 1'b0;
    check("R2 wrap", count_out, 16'h0000);
    check("R7 ovf while disarmed", ovf_flag, 1);
  endtask

  task automatic t_match();
    bus_wr(A_CTRL, 8'h01);
    bus_wr(A_FLG, 8'h00);
    bus_wr(A_CLO, 8'h10);
    check("R5 low byte disarms", armed_out, 0);
    bus_wr(A_CHI, 8'h00);
    check("R5 high byte arms", armed_out, 1);
    load_count(16'h000E);
    check("R3 low before match", pwm_out, 0);
    tb_ce = 1'b1;
    step(1);
    check("R3 below cmp", pwm_out, 0);
    step(1);
    tb_ce = 1'b0;
    check("R3 count at cmp", count_out, 16'h0010);
    check("R3 high at cmp", pwm_out, 1);
    check("R6 flag on match", match_flag, 1);
    // R10: stalled timebase must not retrigger
    bus_wr(A_FLG, 8'h02);
    step(4);
    check("R10 no retrigger", match_flag, 0);
    check("R10 count held", count_out, 16'h0010);
    // overflow clears
    load_count(16'hFFFD);
    bus_wr(A_FLG, 8'h00);
    tb_ce = 1'b1;
    step(2);
    check("R4 high at FFFF", pwm_out, 1);
    step(1);
    tb_ce = 1'b0;
    check("R4 low after wrap", pwm_out, 0);
    check("R7 ovf flag", ovf_flag, 1);
    check("R8 match flag sticky", match_flag, 0);
  endtask

  task automatic t_priority();
    load_count(16'h000F);
    // set (match) and clear land on the same edge
    tb_ce = 1'b1; wr_en = 1'b1; wr_addr = A_FLG; wr_data = 8'h00;
    @(negedge clk);
    tb_ce = 1'b0; wr_en = 1'b0;
    check("R8 set beats clear", match_flag, 1);
    check("R8 ovf cleared", ovf_flag, 0);
    step(3);
    check("R8 flag sticky", match_flag, 1);
    bus_wr(A_FLG, 8'h03);
    check("R8 write 1 keeps", match_flag, 1);
  endtask

  task automatic t_flag_enable();
    bus_wr(A_CTRL, 8'h04);
    bus_wr(A_FLG, 8'h00);
    load_count(16'h000F);
    tb_ce = 1'b1; step(1); tb_ce = 1'b0;
    check("R6 pwm still set", pwm_out, 1);
    check("R6 no flag when disabled", match_flag, 0);
  endtask

  task automatic t_irq();
    bus_wr(A_CTRL, 8'h07);
    check("R9 no flag no irq", match_irq, 0);
    load_count(16'h000F);
    tb_ce = 1'b1; step(1); tb_ce = 1'b0;
    check("R9 irq raised", match_irq, 1);
    bus_wr(A_CTRL, 8'h06);
    check("R9 mat_en off", match_irq, 0);
    check("R9 flag kept", match_flag, 1);
    bus_wr(A_CTRL, 8'h05);
    check("R9 irq_en off", match_irq, 0);
    bus_wr(A_CTRL, 8'h07);
    check("R9 irq again", match_irq, 1);
  endtask

  task automatic t_disarm();
    check("R5 pwm high before", pwm_out, 1);
    bus_wr(A_CLO, 8'h20);
    check("R5 disarmed", armed_out, 0);
    step(1);
    check("R5 pwm forced low", pwm_out, 0);
    load_count(16'h001C);
    tb_ce = 1'b1; step(6); tb_ce = 1'b0;
    check("R5 no match while disarmed", pwm_out, 0);
    bus_wr(A_CHI, 8'h00);
    load_count(16'h001F);
    tb_ce = 1'b1; step(1); tb_ce = 1'b0;
    check("R3 rearmed match", pwm_out, 1);
    bus_wr(A_CTRL, 8'h03);
    step(1);
    check("R5 ctrl disarm low", pwm_out, 0);
  endtask

  task automatic t_min_duty();
    bus_wr(A_CLO, 8'hFF);
    bus_wr(A_CHI, 8'hFF);
    load_count(16'hFFFD);
    tb_ce = 1'b1;
    step(1);
    check("R4 FFFE low", pwm_out, 0);
    step(1);
    check("R4 FFFF high", pwm_out, 1);
    step(1);
    check("R4 0000 low", pwm_out, 0);
    step(1);
    tb_ce = 1'b0;
    check("R4 0001 low", pwm_out, 0);
  endtask

  task automatic t_full_duty();
    int highs;
    bus_wr(A_CLO, 8'h00);
    bus_wr(A_CHI, 8'h00);
    load_count(16'hFFFF);
    bus_wr(A_FLG, 8'h00);
    tb_ce = 1'b1;
    step(1);
    check("R4 cmp0 set at zero", pwm_out, 1);
    highs = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (pwm_out === 1'b1) highs++;
    end
    tb_ce = 1'b0;
    check("R4 cmp0 full period high", highs, high_steps(0));
    check("R4 cmp0 end count", count_out, 16'h0000);
    check("R7 ovf each wrap", ovf_flag, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_counter();
    t_match();
    t_priority();
    t_flag_enable();
    t_irq();
    t_disarm();
    t_min_duty();
    t_full_duty();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule